// File: doc/BRIEF.md
# Strobed Asynchronous Bus Master

This block carries out single read and write transfers on a 16-bit asynchronous bus. The bus has an active-low address strobe, a read/write line, separate active-low strobes for the upper and lower byte lanes, and an active-low acknowledge input from the addressed slave. A request port accepts the address, write data, a size flag (byte or word) and a direction flag. The block then sequences the bus and returns a one-cycle completion pulse, together with the read data.

A transfer passes through four phases. First the address is placed on the bus and the address strobe is asserted. One cycle later the data strobes are asserted. The block then waits, with no time limit, for the acknowledge input, which arrives through a two-stage synchronizer. On acknowledge it latches any read data, releases all strobes and signals completion. A new request is taken only after the slave has withdrawn its acknowledge.

Byte lanes are selected by address bit 0. An even address uses the upper lane and an odd address uses the lower lane. A byte write places the same byte on both lanes. A static 8-bit mode input keeps the upper strobe released and moves every transfer onto the lower lane.

Top module: `sbus_master`

## Requirements
- R1: After reset, and whenever req_ready is high, as_n, uds_n and lds_n are 1, rw is 1, dout_en is 0 and done is 0.
- R2: When req_valid is high and req_ready is high at a clock edge, the request is accepted. In the next cycle as_n is 0, bus_addr equals req_addr, and uds_n and lds_n are still 1. The data strobes fall exactly one cycle after the address strobe.
- R3: In the data phase, outside 8-bit mode, the strobes are set as follows. A word transfer drives uds_n=0 and lds_n=0. A byte transfer with address bit 0 = 0 drives only uds_n=0. A byte transfer with address bit 0 = 1 drives only lds_n=0.
- R4: While a read transfer is active, rw is 1 and dout_en is 0. While a write transfer is active, rw is 0 and dout_en is 1.
- R5: A word write drives dout = req_wdata. A byte write drives req_wdata[7:0] on both dout[15:8] and dout[7:0].
- R6: On acknowledge of a read, rdata is loaded as follows. A word read returns the full din. A byte read returns the selected lane in rdata[7:0] with rdata[15:8] = 0: the upper lane for an even address and the lower lane for an odd address. rdata holds this value until the next read completes.
- R7: The data strobes and the address strobe stay asserted until ack_n, after two synchronizer stages, is seen low. This happens three clock edges after ack_n falls. At that edge all strobes return to 1 and done is high for exactly one cycle.
- R8: After done, req_ready stays 0 while ack_n is held low. req_ready rises on the third clock edge after ack_n returns to 1.
- R9: When mode8 is 1 at acceptance, uds_n stays 1 for the whole transfer and lds_n is used for every transfer. A write drives req_wdata[7:0] on both lanes. A read returns din[7:0] zero-extended, whatever the size or address bit 0.
- R10: bus_addr is stable for as long as as_n stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode8 | input | 1 | 8-bit bus mode, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data from the last completed read |
| bus_addr | output | ADDR_W | Bus address |
| as_n | output | 1 | Address strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| uds_n | output | 1 | Upper lane strobe, active low |
| lds_n | output | 1 | Lower lane strobe, active low |
| dout | output | 16 | Bus write data |
| dout_en | output | 1 | Drive enable for dout |
| din | input | 16 | Bus read data |
| ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
A wrong state in the sequencer shows up directly on the bus strobes.

- A skipped address phase makes the data strobes fall in the same cycle as as_n.
- A lost acknowledge leaves the strobes low.
- An early return to idle raises req_ready while ack_n is still low.

Each of these appears within one to three cycles of the event that caused it. The bench measures the exact edge count from acknowledge to done, and from acknowledge release to req_ready, so the synchronizer depth is checked as well.

A wrong lane decode shows in the first data-phase cycle, as a wrong strobe pair or unreplicated write data. It also shows at done, as the wrong byte in rdata.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2,
    ST_TERM = 2'd3
  } bus_state_e;
endpackage

// File: rtl/sbus_sync.sv
// Multi-stage synchronizer with a selectable reset value.
module sbus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sbus_lane.sv
// Byte-lane decode: strobe selection, write replication, read extraction.
module sbus_lane #(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic          word,
  input  logic          a0,
  input  logic          m8,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] din,
  output logic          sel_u,
  output logic          sel_l,
  output logic [DW-1:0] lane_wdata,
  output logic [DW-1:0] rdata_ext
);
  logic [BYTE_W-1:0] wbyte;
  assign wbyte = wdata[BYTE_W-1:0];

  always_comb begin
    sel_u      = 1'b0;
    sel_l      = 1'b0;
    lane_wdata = {wbyte, wbyte};
    rdata_ext  = '0;
    if (m8) begin
      sel_l                  = 1'b1;
      rdata_ext[BYTE_W-1:0]  = din[BYTE_W-1:0];
    end else if (word) begin
      sel_u      = 1'b1;
      sel_l      = 1'b1;
      lane_wdata = wdata;
      rdata_ext  = din;
    end else if (!a0) begin
      sel_u                  = 1'b1;
      rdata_ext[BYTE_W-1:0]  = din[DW-1:BYTE_W];
    end else begin
      sel_l                  = 1'b1;
      rdata_ext[BYTE_W-1:0]  = din[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/sbus_fsm.sv
// Transfer sequencer with registered strobe outputs.
module sbus_fsm
  import sbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic ack_s,
  input  logic sel_u,
  input  logic sel_l,
  output logic req_ready,
  output logic accept,
  output logic busy,
  output logic capture,
  output logic done,
  output logic as_n,
  output logic uds_n,
  output logic lds_n
);
  bus_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: if (ack_s) state_d = ST_TERM;
      ST_TERM: if (!ack_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      as_n    <= 1'b1;
      uds_n   <= 1'b1;
      lds_n   <= 1'b1;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      as_n    <= !(state_d == ST_ADDR || state_d == ST_STRB);
      uds_n   <= !(state_d == ST_STRB && sel_u);
      lds_n   <= !(state_d == ST_STRB && sel_l);
      done    <= capture;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign busy      = !req_ready;
  assign capture   = (state_q == ST_STRB) && ack_s;
endmodule

// File: rtl/sbus_master.sv
module sbus_master #(
  parameter int ADDR_W      = 24,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode8,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              as_n,
  output logic              rw,
  output logic              uds_n,
  output logic              lds_n,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  input  logic [DW-1:0]     din,
  input  logic              ack_n
);
  logic rst_s_n, ack_raw_s, ack_s;
  logic accept, busy, capture, sel_u, sel_l;
  logic wr_q, word_q, m8_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, lane_wdata, rdata_ext;

  sbus_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  sbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_s_n), .d(ack_n), .q(ack_raw_s)
  );
  assign ack_s = !ack_raw_s;

  sbus_lane #(.BYTE_W(BYTE_W)) u_lane (
    .word(word_q), .a0(addr_q[0]), .m8(m8_q), .wdata(wdata_q), .din(din),
    .sel_u(sel_u), .sel_l(sel_l), .lane_wdata(lane_wdata), .rdata_ext(rdata_ext)
  );

  sbus_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .req_valid(req_valid), .ack_s(ack_s),
    .sel_u(sel_u), .sel_l(sel_l), .req_ready(req_ready), .accept(accept),
    .busy(busy), .capture(capture), .done(done),
    .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n)
  );

  // Request capture, enabled on acceptance.
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      m8_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
      word_q  <= req_word;
      m8_q    <= mode8;
    end
  end

  // Read data capture, enabled on acknowledge.
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                rdata_q <= '0;
    else if (capture && !wr_q)   rdata_q <= rdata_ext;
  end

  assign bus_addr = addr_q;
  assign rw       = !(busy && wr_q);
  assign dout_en  = busy && wr_q;
  assign dout     = lane_wdata;
  assign rdata    = rdata_q;
endmodule

// File: rtl/sbus_master_chk.sv
module sbus_master_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode8,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              as_n,
  input logic              rw,
  input logic              uds_n,
  input logic              lds_n,
  input logic              dout_en
);
  logic m8_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      m8_seen <= 1'b0;
    else if (req_valid && req_ready) m8_seen <= mode8;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (as_n && uds_n && lds_n && rw && !dout_en && !done));
  // R2
  addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!as_n && uds_n && lds_n));
  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && rw) |-> !dout_en);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (as_n && uds_n && lds_n));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m8_seen && !req_ready) |-> uds_n);
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !$past(as_n)) |-> $stable(bus_addr));
endmodule

bind sbus_master sbus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode8(mode8), .req_valid(req_valid),
  .req_ready(req_ready), .done(done), .bus_addr(bus_addr), .as_n(as_n),
  .rw(rw), .uds_n(uds_n), .lds_n(lds_n), .dout_en(dout_en)
);

// File: tb/sbus_master_bench.sv
module sbus_master_bench;
  localparam int AW = 24;

  typedef struct packed {
    logic          wr;
    logic          word;
    logic          m8;
    logic [AW-1:0] addr;
    logic [15:0]   wdata;
    logic [15:0]   din;
    logic          eu;
    logic          el;
    logic [15:0]   edout;
    logic [15:0]   erd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 24'h001000, 16'h0000, 16'hA55A, 1'b0, 1'b0, 16'h0000, 16'hA55A},
    '{1'b0, 1'b0, 1'b0, 24'h001001, 16'h0000, 16'h1234, 1'b1, 1'b0, 16'h0000, 16'h0034},
    '{1'b0, 1'b0, 1'b0, 24'h002000, 16'h0000, 16'hBEEF, 1'b0, 1'b1, 16'h0000, 16'h00BE},
    '{1'b1, 1'b1, 1'b0, 24'h003000, 16'hCAFE, 16'h0000, 1'b0, 1'b0, 16'hCAFE, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 24'h003002, 16'hAB77, 16'h0000, 1'b0, 1'b1, 16'h7777, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 24'h003003, 16'h00C3, 16'h0000, 1'b1, 1'b0, 16'hC3C3, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 24'h004000, 16'h0000, 16'h5A69, 1'b1, 1'b0, 16'h0000, 16'h0069},
    '{1'b1, 1'b1, 1'b1, 24'h004001, 16'h1288, 16'h0000, 1'b1, 1'b0, 16'h8888, 16'h0000},
    '{1'b0, 1'b1, 1'b1, 24'h005002, 16'h0000, 16'hFF11, 1'b1, 1'b0, 16'h0000, 16'h0011},
    '{1'b0, 1'b0, 1'b1, 24'h005003, 16'h0000, 16'hE2D4, 1'b1, 1'b0, 16'h0000, 16'h00D4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode8 = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, din = '0;
  logic ack_n = 1'b1;
  logic req_ready, done, as_n, rw, uds_n, lds_n, dout_en;
  logic [15:0] rdata, dout;
  logic [AW-1:0] bus_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sbus_master #(.ADDR_W(AW)) u_sbus_master (
    .clk(clk), .rst_n(rst_n), .mode8(mode8), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .as_n(as_n), .rw(rw), .uds_n(uds_n), .lds_n(lds_n),
    .dout(dout), .dout_en(dout_en), .din(din), .ack_n(ack_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One transfer: ack is delayed by wait_cyc cycles and held low for hold_cyc
  // cycles after done.
  task automatic run_xfer(input vec_t v, input int wait_cyc, input int hold_cyc);
    int n;
    @(negedge clk);
    check("R1 ready before request", {31'd0, req_ready}, 32'd1);
    mode8 = v.m8; req_write = v.wr; req_word = v.word;
    req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 address phase as_n,uds_n,lds_n", {29'd0, as_n, uds_n, lds_n}, 32'b011);
    check("R2 bus_addr", {8'd0, bus_addr}, {8'd0, v.addr});
    @(negedge clk);
    check("R3 R9 strobes in data phase", {30'd0, uds_n, lds_n}, {30'd0, v.eu, v.el});
    check("R4 rw and dout_en", {30'd0, rw, dout_en}, {30'd0, !v.wr, v.wr});
    if (v.wr) check("R5 R9 write lane data", {16'd0, dout}, {16'd0, v.edout});
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk);
      if (as_n || (uds_n && lds_n) || done)
        check("R7 strobes held while waiting", {29'd0, as_n, uds_n & lds_n, done}, 32'd0);
    end
    if (wait_cyc > 0)
      check("R7 strobes still asserted after wait", {30'd0, as_n, uds_n & lds_n}, 32'd0);
    din = v.din; ack_n = 1'b0;
    n = 0;
    while (!done && n < 10) begin
      @(negedge clk);
      n++;
    end
    check("R7 edges from ack to done", n, 32'd3);
    check("R10 bus_addr held to done", {8'd0, bus_addr}, {8'd0, v.addr});
    check("R7 strobes released at done", {29'd0, as_n, uds_n, lds_n}, 32'b111);
    if (!v.wr) check("R6 R9 read data", {16'd0, rdata}, {16'd0, v.erd});
    din = 16'h0000;
    @(negedge clk);
    check("R7 done one cycle", {31'd0, done}, 32'd0);
    for (int i = 0; i < hold_cyc; i++) begin
      @(negedge clk);
      if (req_ready) check("R8 busy while ack held", {31'd0, req_ready}, 32'd0);
    end
    ack_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 not idle two edges after ack release", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check("R8 idle three edges after ack release", {31'd0, req_ready}, 32'd1);
    if (!v.wr) check("R6 rdata held after transfer", {16'd0, rdata}, {16'd0, v.erd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset strobes", {29'd0, as_n, uds_n, lds_n}, 32'b111);
    check("R1 reset rw,dout_en,done", {29'd0, rw, dout_en, done}, 32'b100);
    check("R1 reset ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {28'd0, as_n, uds_n, lds_n, rw}, 32'b1111);

    for (int k = 0; k < NV; k++) run_xfer(VECS[k], 0, 0);

    // R7: long acknowledge wait keeps the strobes asserted
    run_xfer(VECS[0], 40, 0);
    // R8: acknowledge held low long after done
    run_xfer(VECS[4], 0, 12);
    // R6: a write between reads leaves rdata unchanged
    run_xfer(VECS[3], 0, 0);
    check("R6 rdata unchanged by write", {16'd0, rdata}, {16'd0, VECS[0].erd});

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule